// File: doc/BRIEF.md
# ROM Pattern Lookup Unit

This unit carries out the two-cycle constant-table instruction of a small 4-bit microcontroller. When the sequencer issues the instruction, the unit captures the program counter, the 3-bit operand p, the accumulator, the B register and the carry flag. From these it builds a 12-bit lookup address. The address has three fields: a 1-bit bank in bit 11, a 5-bit page in bits 10:6, and a 6-bit word address in bits 5:0. The word field is replaced by CPU registers. The page and bank fields are the current PC fields ORed with further CPU state and with the operand. Code in bank 1 can therefore only reach bank 1, while code in bank 0 picks either bank through the top bit of p.

The 10-bit ROM word at that address is read in the first cycle and acted on in the second. Its two top bits are command bits. Bit 8 sends the lower eight bits to the accumulator and B register. Bit 9 sends them to output registers R2 and R3. Both bits set sends them to both pairs. In each pair the upper nibble goes to the accumulator or R2. The program counter itself is never changed. The unit hands back the incremented PC so execution continues at the next instruction.

The ROM is a behavioural model inside the unit. Its contents are a fixed function of the address, given in R6.

Top module: `pattern_lookup_unit`

## Requirements
- R1: While reset is applied, busy, done, ab_we and io_we are all 0.
- R2: A start sampled while idle makes busy 1 in the next cycle, with done 0. In the cycle after that, busy and done are both 1. That second cycle is the only one in which ab_we or io_we may be 1.
- R3: Bits 5:0 of the lookup address equal {B[1:0], A[3:0]} as captured at start.
- R4: Bits 10:6 of the lookup address equal PC[10:6] ORed with {B[3:2], carry, p[1], p[0]}.
- R5: Bit 11 of the lookup address equals PC[11] OR p[2]. When PC[11] is 1, the lookup always stays in bank 1.
- R6: The ROM word at address X has command bits {bit9, bit8} = X[1:0]. Its data bits 7:0 are X[9:2] XOR {X[11:10] repeated four times}.
- R7: When word bit 8 is 1, ab_we is 1 in the done cycle, acc_wdata equals word bits 7:4 and b_wdata equals word bits 3:0.
- R8: When word bit 9 is 1, io_we is 1 in the done cycle, r2_wdata equals word bits 7:4 and r3_wdata equals word bits 3:0. When both command bits are 1, both loads happen together.
- R9: When both command bits are 0, neither ab_we nor io_we is asserted.
- R10: In the done cycle, pc_next equals the captured PC plus 1, modulo 4096. It does not depend on the lookup address.
- R11: A start while busy is ignored. Changes on pc_in, opnd_p, acc_in, b_in or carry_in after the accepting edge do not affect the running instruction. rom_addr stays fixed for both cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Issue the lookup instruction |
| pc_in | input | 12 | Current program counter {bank, page, word} |
| opnd_p | input | 3 | Instruction operand p |
| acc_in | input | 4 | Accumulator value |
| b_in | input | 4 | B register value |
| carry_in | input | 1 | Carry flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Second cycle: writes and PC advance take effect |
| rom_addr | output | 12 | Lookup address formed for the instruction |
| ab_we | output | 1 | Write strobe for the accumulator and B register |
| acc_wdata | output | 4 | Data for the accumulator |
| b_wdata | output | 4 | Data for the B register |
| io_we | output | 1 | Write strobe for R2 and R3 |
| r2_wdata | output | 4 | Data for R2 |
| r3_wdata | output | 4 | Data for R3 |
| pc_next | output | 12 | Program counter to resume at |

## Verification
Counting from the edge that accepts start, busy is due one edge later. The ROM word, the write strobes, the write data and pc_next are all due two edges later, in the single done cycle. The driver task samples at the falling edge after each of those two rising edges. It checks busy and done there, so any cycle of latency gained or lost is caught. The expected address and loads are pushed into a queue at issue time. A monitor pops one item per done pulse at the falling edge and compares every field, so a missing, duplicated or early result shows up as a mismatch or an empty queue.

// File: rtl/patlu_pkg.sv
package patlu_pkg;

  typedef enum logic [1:0] {
    PL_IDLE  = 2'd0,
    PL_FETCH = 2'd1,
    PL_LOAD  = 2'd2
  } pl_step_e;

  localparam int unsigned PL_NIB_W  = 4;
  localparam int unsigned PL_OPND_W = 3;

endpackage

// File: rtl/patlu_ctrl.sv
module patlu_ctrl
  import patlu_pkg::*;
#(
  parameter int unsigned NIB_W  = PL_NIB_W,
  parameter int unsigned OPND_W = PL_OPND_W,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [OPND_W-1:0] opnd_p,
  input  logic [NIB_W-1:0]  acc_in,
  input  logic [NIB_W-1:0]  b_in,
  input  logic              carry_in,
  output pl_step_e          step,
  output logic [ADDR_W-1:0] pc_lat,
  output logic [OPND_W-1:0] p_lat,
  output logic [NIB_W-1:0]  a_lat,
  output logic [NIB_W-1:0]  b_lat,
  output logic              c_lat,
  output logic              busy,
  output logic              fetch,
  output logic              load
);

  pl_step_e step_d, step_q;
  logic     accept;

  // next-state logic
  always_comb begin
    step_d = step_q;
    unique case (step_q)
      PL_IDLE:  if (start) step_d = PL_FETCH;
      PL_FETCH: step_d = PL_LOAD;
      PL_LOAD:  step_d = PL_IDLE;
      default:  step_d = PL_IDLE;
    endcase
  end

  assign accept = (step_q == PL_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= PL_IDLE;
    else        step_q <= step_d;
  end

  // operand capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_lat <= '0;
      p_lat  <= '0;
      a_lat  <= '0;
      b_lat  <= '0;
      c_lat  <= 1'b0;
    end else if (accept) begin
      pc_lat <= pc_in;
      p_lat  <= opnd_p;
      a_lat  <= acc_in;
      b_lat  <= b_in;
      c_lat  <= carry_in;
    end
  end

  assign step  = step_q;
  assign fetch = (step_q == PL_FETCH);
  assign load  = (step_q == PL_LOAD);
  assign busy  = fetch | load;

  a_r2_fetch_then_load: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == PL_FETCH) |=> (step_q == PL_LOAD));
  a_r2_load_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == PL_LOAD) |=> (step_q == PL_IDLE));
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != PL_IDLE) |=> (step_q != PL_FETCH));
  a_r11_hold_operands: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == PL_LOAD) |-> ($stable(pc_lat) && $stable(p_lat) && $stable(a_lat)
                             && $stable(b_lat) && $stable(c_lat)));

endmodule

// File: rtl/patlu_addr_gen.sv
module patlu_addr_gen #(
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned OPND_W  = 3,
  parameter int unsigned PAGE_W  = NIB_W + OPND_W - 2,
  parameter int unsigned WADDR_W = NIB_W + 2,
  parameter int unsigned ADDR_W  = 1 + PAGE_W + WADDR_W
) (
  input  logic [ADDR_W-WADDR_W-1:0] pc_hi,
  input  logic [OPND_W-1:0]         p_lat,
  input  logic [NIB_W-1:0]          a_lat,
  input  logic [NIB_W-1:0]          b_lat,
  input  logic                      c_lat,
  output logic [ADDR_W-1:0]         addr
);

  logic [WADDR_W-1:0] word_f;
  logic [PAGE_W-1:0]  page_mask;
  logic [PAGE_W-1:0]  page_f;
  logic               bank_f;

  // word field is substituted by B low bits and the accumulator
  assign word_f    = {b_lat[1:0], a_lat};
  // page field is merged with B high bits, carry and operand low bits
  assign page_mask = {b_lat[NIB_W-1:2], c_lat, p_lat[OPND_W-2:0]};
  assign page_f    = pc_hi[PAGE_W-1:0] | page_mask;
  // bank can only be raised, never cleared
  assign bank_f    = pc_hi[PAGE_W] | p_lat[OPND_W-1];

  assign addr = {bank_f, page_f, word_f};

endmodule

// File: rtl/patlu_rom.sv
module patlu_rom #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ROM_W  = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [ROM_W-1:0]  q
);

  localparam int unsigned REP = DATA_W / 2;

  // behavioural contents: a fixed function of the address
  function automatic logic [ROM_W-1:0] content(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] d;
    d = a[DATA_W+1:2] ^ {REP{a[ADDR_W-1 -: 2]}};
    return {a[1:0], d};
  endfunction

  logic [ROM_W-1:0] q_d;

  always_comb q_d = content(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (rd_en) q <= q_d;
  end

endmodule

// File: rtl/patlu_steer.sv
module patlu_steer #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned ROM_W = 2 * NIB_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROM_W-1:0] word,
  output logic             ab_we,
  output logic [NIB_W-1:0] acc_wdata,
  output logic [NIB_W-1:0] b_wdata,
  output logic             io_we,
  output logic [NIB_W-1:0] r2_wdata,
  output logic [NIB_W-1:0] r3_wdata
);

  logic             cmd_ab;
  logic             cmd_io;
  logic [NIB_W-1:0] hi_nib;
  logic [NIB_W-1:0] lo_nib;

  assign cmd_ab = word[ROM_W-2];
  assign cmd_io = word[ROM_W-1];
  assign hi_nib = word[2*NIB_W-1:NIB_W];
  assign lo_nib = word[NIB_W-1:0];

  assign ab_we     = load & cmd_ab;
  assign io_we     = load & cmd_io;
  assign acc_wdata = hi_nib;
  assign b_wdata   = lo_nib;
  assign r2_wdata  = hi_nib;
  assign r3_wdata  = lo_nib;

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (word[ROM_W-1:ROM_W-2] == 2'b00) |-> (!ab_we && !io_we));
  a_r2_strobe_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_we || io_we) |-> load);

endmodule

// File: rtl/pattern_lookup_unit.sv
module pattern_lookup_unit
  import patlu_pkg::*;
#(
  parameter int unsigned NIB_W  = PL_NIB_W,
  parameter int unsigned OPND_W = PL_OPND_W,
  localparam int unsigned PAGE_W  = NIB_W + OPND_W - 2,
  localparam int unsigned WADDR_W = NIB_W + 2,
  localparam int unsigned ADDR_W  = 1 + PAGE_W + WADDR_W,
  localparam int unsigned DATA_W  = 2 * NIB_W,
  localparam int unsigned ROM_W   = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [OPND_W-1:0] opnd_p,
  input  logic [NIB_W-1:0]  acc_in,
  input  logic [NIB_W-1:0]  b_in,
  input  logic              carry_in,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              ab_we,
  output logic [NIB_W-1:0]  acc_wdata,
  output logic [NIB_W-1:0]  b_wdata,
  output logic              io_we,
  output logic [NIB_W-1:0]  r2_wdata,
  output logic [NIB_W-1:0]  r3_wdata,
  output logic [ADDR_W-1:0] pc_next
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  pl_step_e          step;
  logic [ADDR_W-1:0] pc_lat;
  logic [OPND_W-1:0] p_lat;
  logic [NIB_W-1:0]  a_lat;
  logic [NIB_W-1:0]  b_lat;
  logic              c_lat;
  logic              fetch;
  logic              load;
  logic [ROM_W-1:0]  rom_q;

  patlu_ctrl #(.NIB_W(NIB_W), .OPND_W(OPND_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .pc_in    (pc_in),
    .opnd_p   (opnd_p),
    .acc_in   (acc_in),
    .b_in     (b_in),
    .carry_in (carry_in),
    .step     (step),
    .pc_lat   (pc_lat),
    .p_lat    (p_lat),
    .a_lat    (a_lat),
    .b_lat    (b_lat),
    .c_lat    (c_lat),
    .busy     (busy),
    .fetch    (fetch),
    .load     (load)
  );

  patlu_addr_gen #(.NIB_W(NIB_W), .OPND_W(OPND_W)) u_addr (
    .pc_hi (pc_lat[ADDR_W-1:WADDR_W]),
    .p_lat (p_lat),
    .a_lat (a_lat),
    .b_lat (b_lat),
    .c_lat (c_lat),
    .addr  (rom_addr)
  );

  patlu_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .clk   (clk),
    .rst_n (rst_i_n),
    .rd_en (fetch),
    .addr  (rom_addr),
    .q     (rom_q)
  );

  patlu_steer #(.NIB_W(NIB_W)) u_steer (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load      (load),
    .word      (rom_q),
    .ab_we     (ab_we),
    .acc_wdata (acc_wdata),
    .b_wdata   (b_wdata),
    .io_we     (io_we),
    .r2_wdata  (r2_wdata),
    .r3_wdata  (r3_wdata)
  );

  assign done    = load;
  // the program counter is left alone; only its successor is offered
  assign pc_next = pc_lat + ADDR_W'(1);

  a_r5_bank_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && pc_lat[ADDR_W-1]) |-> rom_addr[ADDR_W-1]);
  a_r10_pc_advance: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && $past(step == PL_FETCH)) |-> (pc_next == ADDR_W'($past(pc_in, 2) + 1'b1)));
  a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_i_n)
    (step == PL_LOAD) |-> $stable(rom_addr));

endmodule

// File: tb/tb_pattern_lookup_unit.sv
module tb_pattern_lookup_unit;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, carry_in;
  logic [11:0] pc_in;
  logic [2:0]  opnd_p;
  logic [3:0]  acc_in, b_in;
  logic        busy, done, ab_we, io_we;
  logic [11:0] rom_addr, pc_next;
  logic [3:0]  acc_wdata, b_wdata, r2_wdata, r3_wdata;

  pattern_lookup_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .opnd_p(opnd_p),
    .acc_in(acc_in), .b_in(b_in), .carry_in(carry_in), .busy(busy), .done(done),
    .rom_addr(rom_addr), .ab_we(ab_we), .acc_wdata(acc_wdata), .b_wdata(b_wdata),
    .io_we(io_we), .r2_wdata(r2_wdata), .r3_wdata(r3_wdata), .pc_next(pc_next)
  );

  typedef struct {
    logic [11:0] addr;
    logic        ab;
    logic        io;
    logic [3:0]  hi;
    logic [3:0]  lo;
    logic [11:0] pcn;
  } exp_t;

  exp_t sb[$];
  int   errs = 0;
  int   checks = 0;
  int   stray = 0;
  bit   live = 1'b0;
  bit   ended = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // R6 contents, taken from the requirement
  function automatic logic [9:0] rom_word(input logic [11:0] x);
    logic [7:0] d;
    d = x[9:2] ^ {x[11:10], x[11:10], x[11:10], x[11:10]};
    return {x[1:0], d};
  endfunction

  task automatic issue(input logic [11:0] pc, input logic [2:0] p,
                       input logic [3:0] a, input logic [3:0] b,
                       input logic c, input bit poke);
    exp_t       e;
    logic [9:0] w;
    @(negedge clk);
    pc_in = pc; opnd_p = p; acc_in = a; b_in = b; carry_in = c; start = 1'b1;
    e.addr = {pc[11] | p[2], pc[10:6] | {b[3:2], c, p[1:0]}, b[1:0], a};
    w      = rom_word(e.addr);
    e.ab   = w[8];
    e.io   = w[9];
    e.hi   = w[7:4];
    e.lo   = w[3:0];
    e.pcn  = pc + 12'd1;
    sb.push_back(e);
    @(negedge clk);
    chk(busy && !done, "R2", "first cycle busy/done", {busy, done}, 2'b10);
    // R11: scramble operands and poke start while busy
    start = poke;
    pc_in = ~pc; opnd_p = ~p; acc_in = ~a; b_in = ~b; carry_in = ~c;
    @(negedge clk);
    start = 1'b0;
    chk(busy && done, "R2", "second cycle busy/done", {busy, done}, 2'b11);
    @(negedge clk);
    chk(!busy && !done, "R11", "idle after instruction", {busy, done}, 2'b00);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (live) begin
      if ((ab_we || io_we) && !done) stray++;
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rom_addr[5:0] == e.addr[5:0], "R3", "word address", rom_addr[5:0], e.addr[5:0]);
          chk(rom_addr[10:6] == e.addr[10:6], "R4", "page", rom_addr[10:6], e.addr[10:6]);
          chk(rom_addr[11] == e.addr[11], "R5", "bank", rom_addr[11], e.addr[11]);
          chk(ab_we == e.ab, e.ab ? "R7" : "R9", "ab_we", ab_we, e.ab);
          chk(io_we == e.io, e.io ? "R8" : "R9", "io_we", io_we, e.io);
          if (e.ab)
            chk({acc_wdata, b_wdata} == {e.hi, e.lo}, "R7", "acc/b data (R6 word)",
                {acc_wdata, b_wdata}, {e.hi, e.lo});
          if (e.io)
            chk({r2_wdata, r3_wdata} == {e.hi, e.lo}, "R8", "r2/r3 data (R6 word)",
                {r2_wdata, r3_wdata}, {e.hi, e.lo});
          chk(pc_next == e.pcn, "R10", "pc_next", pc_next, e.pcn);
        end
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pc_in = '0; opnd_p = '0;
    acc_in = '0; b_in = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ab_we && !io_we, "R1", "outputs in reset",
        {busy, done, ab_we, io_we}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    live = 1'b1;

    // R9: command bits 00 (A[1:0]=00)
    issue(12'h000, 3'd0, 4'h4, 4'h0, 1'b0, 1'b0);
    // R7: command 01, R8: command 10, both: command 11
    issue(12'h000, 3'd0, 4'h5, 4'h0, 1'b0, 1'b0);
    issue(12'h040, 3'd1, 4'h6, 4'h1, 1'b0, 1'b1);
    issue(12'h0C0, 3'd2, 4'h7, 4'h2, 1'b1, 1'b0);
    // R4: page OR with B high bits, carry and p low bits
    issue(12'h280, 3'd3, 4'hB, 4'hC, 1'b1, 1'b1);
    // R5: bank 0 code, p2 selects bank 1
    issue(12'h123, 3'd4, 4'h9, 4'h3, 1'b0, 1'b0);
    // R5: bank 1 code with p2=0 stays in bank 1
    issue(12'h8A5, 3'd0, 4'h3, 4'h0, 1'b0, 1'b1);
    // R10: PC wrap at the top of the space
    issue(12'hFFF, 3'd7, 4'hF, 4'hF, 1'b1, 1'b0);
    issue(12'h7FF, 3'd0, 4'h1, 4'h2, 1'b0, 1'b0);

    for (int i = 0; i < 40; i++) begin
      issue(12'($urandom), 3'($urandom), 4'($urandom), 4'($urandom),
            1'($urandom), 1'($urandom));
    end

    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R2", "all results delivered", sb.size(), 0);
    chk(stray == 0, "R2", "strobes outside done", stray, 0);
    finish_run();
  end

endmodule